// File: doc/BRIEF.md
# Day-Hour-Minute-Second Counter with Alarm

This block holds elapsed time as a binary day count plus hours, minutes and seconds. It advances once for every single-cycle pulse on its 1 Hz tick input. That pulse comes from a prescaler outside the block. Software can overwrite the whole time value in one cycle through the load ports.

An alarm value with day, hour, minute and second fields is compared with the time that a tick is about to produce. Each field has a mask bit that forces it to match. When the produced time matches on every field, a sticky alarm flag is raised. The flag stays high until a clear input drops it, so it can drive an interrupt or an output pin directly.

Top module: `dhms_alarm_rtc`

## Requirements
- R1: While reset is high, and in the first cycle after it, the time reads 0:00:00:00 and the alarm flag is low.
- R2: A tick pulse adds one second to the time at the next clock edge. When both tick and load are low, the time holds its value.
- R3: A tick with seconds at 59 or above sets seconds to 0 and carries into minutes. Minutes wrap from 59 to 0 in the same way and carry into hours.
- R4: A tick with hours at 23 or above, and with the carry from minutes present, sets hours to 0 and adds one to the day count.
- R5: The day count wraps from its largest value (2^DAY_W - 1) to 0.
- R6: When load is high, the load values appear on the time outputs after the next clock edge. A tick in the same cycle is ignored.
- R7: The alarm flag rises at the clock edge where a tick (with load low) produces a time equal to the alarm on all unmasked fields. A load never sets the flag.
- R8: Mask bit 0 covers seconds, bit 1 minutes, bit 2 hours and bit 3 days. A set bit makes its field always match. With all four bits set, every tick sets the flag.
- R9: The flag stays high until the clear input is pulsed. If a clear arrives in the same cycle as a tick that sets the flag, the flag stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle 1 Hz advance pulse |
| load_en | input | 1 | Overwrite the time with the load values |
| load_day | input | DAY_W | Day value to load |
| load_hr | input | 5 | Hour value to load |
| load_min | input | 6 | Minute value to load |
| load_sec | input | 6 | Second value to load |
| alm_day | input | DAY_W | Alarm day |
| alm_hr | input | 5 | Alarm hour |
| alm_min | input | 6 | Alarm minute |
| alm_sec | input | 6 | Alarm second |
| alm_mask | input | 4 | Per-field always-match bits (see R8) |
| flag_clr | input | 1 | Clear the alarm flag |
| cur_day | output | DAY_W | Current day count |
| cur_hr | output | 5 | Current hour |
| cur_min | output | 6 | Current minute |
| cur_sec | output | 6 | Current second |
| alarm_flag | output | 1 | Sticky alarm indication |

## Verification
The bench builds the block with DAY_W = 3, so the day count tops out at 7. A single load followed by one tick therefore exercises the full carry chain from seconds through to the day wrap. The hour, minute and second limits keep their real values. Long tick runs of 61 and 125 pulses are used to show the minute and hour carries arising from counting alone, not from loaded values.

// File: rtl/dhms_pkg.sv
package dhms_pkg;

    localparam int HR_W   = 5;
    localparam int MS_W   = 6;
    localparam int SEC_LIM = 60;
    localparam int MIN_LIM = 60;
    localparam int HR_LIM  = 24;

    localparam logic [MS_W-1:0] SEC_LAST = MS_W'(SEC_LIM - 1);
    localparam logic [MS_W-1:0] MIN_LAST = MS_W'(MIN_LIM - 1);
    localparam logic [HR_W-1:0] HR_LAST  = HR_W'(HR_LIM - 1);

    // time of day inside one day
    typedef struct packed {
        logic [HR_W-1:0] hr;
        logic [MS_W-1:0] min;
        logic [MS_W-1:0] sec;
    } tod_t;

    // mask bit positions
    typedef enum int {
        F_SEC = 0,
        F_MIN = 1,
        F_HR  = 2,
        F_DAY = 3
    } field_e;

    // advance a time of day by one second; carry out on day rollover
    function automatic tod_t tod_step(input tod_t t, output logic day_carry);
        tod_t n;
        logic c_min;
        logic c_hr;
        n = t;
        c_min = (t.sec >= SEC_LAST);
        n.sec = c_min ? '0 : t.sec + 1'b1;
        c_hr = c_min && (t.min >= MIN_LAST);
        if (c_min) n.min = (t.min >= MIN_LAST) ? '0 : t.min + 1'b1;
        day_carry = c_hr && (t.hr >= HR_LAST);
        if (c_hr) n.hr = (t.hr >= HR_LAST) ? '0 : t.hr + 1'b1;
        return n;
    endfunction

endpackage

// File: rtl/dhms_counter.sv
module dhms_counter
    import dhms_pkg::*;
#(
    parameter int DAY_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_en,
    input  logic [DAY_W-1:0] load_day,
    input  tod_t             load_tod,
    output logic [DAY_W-1:0] day_q,
    output tod_t             tod_q,
    output logic [DAY_W-1:0] day_nx,
    output tod_t             tod_nx
);

    logic carry;

    always_comb begin
        tod_nx = tod_step(tod_q, carry);
        day_nx = carry ? day_q + 1'b1 : day_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            day_q <= '0;
            tod_q <= '0;
        end else if (load_en) begin
            day_q <= load_day;
            tod_q <= load_tod;
        end else if (tick) begin
            day_q <= day_nx;
            tod_q <= tod_nx;
        end
    end

endmodule

// File: rtl/dhms_match.sv
module dhms_match
    import dhms_pkg::*;
#(
    parameter int DAY_W = 9
) (
    input  logic [DAY_W-1:0] day_a,
    input  tod_t             tod_a,
    input  logic [DAY_W-1:0] day_b,
    input  tod_t             tod_b,
    input  logic [3:0]       mask,
    output logic             hit
);

    logic [3:0] eq;

    always_comb begin
        eq[F_SEC] = (tod_a.sec == tod_b.sec);
        eq[F_MIN] = (tod_a.min == tod_b.min);
        eq[F_HR]  = (tod_a.hr  == tod_b.hr);
        eq[F_DAY] = (day_a     == day_b);
        hit = &(eq | mask);
    end

endmodule

// File: rtl/dhms_flag.sv
module dhms_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic flag_q
);

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (set_req) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

endmodule

// File: rtl/dhms_alarm_rtc.sv
module dhms_alarm_rtc
    import dhms_pkg::*;
#(
    parameter int DAY_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_en,
    input  logic [DAY_W-1:0] load_day,
    input  logic [4:0]       load_hr,
    input  logic [5:0]       load_min,
    input  logic [5:0]       load_sec,
    input  logic [DAY_W-1:0] alm_day,
    input  logic [4:0]       alm_hr,
    input  logic [5:0]       alm_min,
    input  logic [5:0]       alm_sec,
    input  logic [3:0]       alm_mask,
    input  logic             flag_clr,
    output logic [DAY_W-1:0] cur_day,
    output logic [4:0]       cur_hr,
    output logic [5:0]       cur_min,
    output logic [5:0]       cur_sec,
    output logic             alarm_flag
);

    tod_t             load_tod, alm_tod, tod_q, tod_nx;
    logic [DAY_W-1:0] day_q, day_nx;
    logic             hit;
    logic             advance;

    assign load_tod = '{hr: load_hr, min: load_min, sec: load_sec};
    assign alm_tod  = '{hr: alm_hr,  min: alm_min,  sec: alm_sec};
    assign advance  = tick && !load_en;

    dhms_counter #(.DAY_W(DAY_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .load_en(load_en),
        .load_day(load_day), .load_tod(load_tod),
        .day_q(day_q), .tod_q(tod_q), .day_nx(day_nx), .tod_nx(tod_nx)
    );

    dhms_match #(.DAY_W(DAY_W)) u_cmp (
        .day_a(day_nx), .tod_a(tod_nx), .day_b(alm_day), .tod_b(alm_tod),
        .mask(alm_mask), .hit(hit)
    );

    dhms_flag u_flag (
        .clk(clk), .rst(rst), .set_req(advance && hit), .clr_req(flag_clr),
        .flag_q(alarm_flag)
    );

    assign cur_day = day_q;
    assign cur_hr  = tod_q.hr;
    assign cur_min = tod_q.min;
    assign cur_sec = tod_q.sec;

endmodule

// File: rtl/dhms_alarm_chk.sv
module dhms_alarm_chk #(
    parameter int DAY_W = 9
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             load_en,
    input logic [DAY_W-1:0] load_day,
    input logic [4:0]       load_hr,
    input logic [5:0]       load_min,
    input logic [5:0]       load_sec,
    input logic             flag_clr,
    input logic [DAY_W-1:0] cur_day,
    input logic [4:0]       cur_hr,
    input logic [5:0]       cur_min,
    input logic [5:0]       cur_sec,
    input logic             alarm_flag
);

    p_load_r6: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (cur_day == $past(load_day) && cur_hr == $past(load_hr)
                     && cur_min == $past(load_min) && cur_sec == $past(load_sec)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_en) |=> ($stable(cur_sec) && $stable(cur_min)
                                 && $stable(cur_hr) && $stable(cur_day)));

    p_sec_range_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en) |=> (cur_sec < 6'd60 && cur_sec != $past(cur_sec)));

    p_hr_range_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en) |=> (cur_hr < 5'd24));

    p_flag_src_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_flag) |-> $past(tick && !load_en));

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !flag_clr) |=> alarm_flag);

    p_flag_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !tick) |=> !alarm_flag);

endmodule

bind dhms_alarm_rtc dhms_alarm_chk #(.DAY_W(DAY_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .load_en(load_en),
    .load_day(load_day), .load_hr(load_hr), .load_min(load_min), .load_sec(load_sec),
    .flag_clr(flag_clr), .cur_day(cur_day), .cur_hr(cur_hr), .cur_min(cur_min),
    .cur_sec(cur_sec), .alarm_flag(alarm_flag)
);

// File: tb/sim_dhms_alarm_rtc.sv
module sim_dhms_alarm_rtc;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 3;
    localparam int NV = 8;
    // load d,h,m,s ; ticks ; expected d,h,m,s
    localparam int VEC [0:NV-1][0:8] = '{
        '{0, 0,  0,  0,   1, 0, 0, 0, 1},
        '{0, 0,  0, 58,   2, 0, 0, 1, 0},
        '{0, 0, 59, 59,   1, 0, 1, 0, 0},
        '{2, 23, 59, 59,  1, 3, 0, 0, 0},
        '{7, 23, 59, 59,  1, 0, 0, 0, 0},
        '{1, 5, 10, 20,   0, 1, 5, 10, 20},
        '{0, 0,  0,  0, 125, 0, 0, 2, 5},
        '{0, 22, 59, 0,  61, 0, 23, 0, 1}
    };
    localparam string VREQ [0:NV-1] = '{"R2", "R3", "R3", "R4", "R5", "R6", "R3", "R4"};

    logic clk = 0, rst = 1, tick = 0, load_en = 0, flag_clr = 0;
    logic [DW-1:0] load_day = 0, alm_day = 0, cur_day;
    logic [4:0] load_hr = 0, alm_hr = 0, cur_hr;
    logic [5:0] load_min = 0, load_sec = 0, alm_min = 0, alm_sec = 0, cur_min, cur_sec;
    logic [3:0] alm_mask = 0;
    logic alarm_flag;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dhms_alarm_rtc #(.DAY_W(DW)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .load_en(load_en),
        .load_day(load_day), .load_hr(load_hr), .load_min(load_min), .load_sec(load_sec),
        .alm_day(alm_day), .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
        .alm_mask(alm_mask), .flag_clr(flag_clr),
        .cur_day(cur_day), .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
        .alarm_flag(alarm_flag)
    );

    function automatic int packt(int d, int h, int m, int s);
        return d * 1000000 + h * 10000 + m * 100 + s;
    endfunction

    function automatic int now();
        return packt(int'(cur_day), int'(cur_hr), int'(cur_min), int'(cur_sec));
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(int d, int h, int m, int s);
        load_en = 1; load_day = DW'(d); load_hr = 5'(h); load_min = 6'(m); load_sec = 6'(s);
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1;
            @(negedge clk);
        end
        tick = 0;
    endtask

    task automatic set_alarm(int d, int h, int m, int s, logic [3:0] mk);
        alm_day = DW'(d); alm_hr = 5'(h); alm_min = 6'(m); alm_sec = 6'(s); alm_mask = mk;
    endtask

    task automatic clear_flag();
        flag_clr = 1;
        @(negedge clk);
        flag_clr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", now(), 0);
        chk("R1", int'(alarm_flag), 0);
        rst = 0;
        @(negedge clk);
        chk("R1", now(), 0);
        chk("R1", int'(alarm_flag), 0);

        // unreachable alarm during the table
        set_alarm(6, 6, 6, 6, 4'b0000);
        for (int v = 0; v < NV; v++) begin
            do_load(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
            ticks(VEC[v][4]);
            chk(VREQ[v], now(), packt(VEC[v][5], VEC[v][6], VEC[v][7], VEC[v][8]));
        end

        // R2: hold with no tick
        do_load(3, 4, 5, 6);
        repeat (5) @(negedge clk);
        chk("R2", now(), packt(3, 4, 5, 6));

        // R6: load beats same-cycle tick
        tick = 1;
        do_load(4, 10, 20, 30);
        tick = 0;
        chk("R6", now(), packt(4, 10, 20, 30));

        // R7: exact match
        set_alarm(1, 2, 3, 5, 4'b0000);
        clear_flag();
        do_load(1, 2, 3, 3);
        ticks(1);
        chk("R7", int'(alarm_flag), 0);
        ticks(1);
        chk("R7", int'(alarm_flag), 1);
        // R9: sticky, then clear
        ticks(3);
        chk("R9", int'(alarm_flag), 1);
        clear_flag();
        chk("R9", int'(alarm_flag), 0);

        // R7: load onto alarm value does not set flag
        do_load(1, 2, 3, 5);
        chk("R7", int'(alarm_flag), 0);

        // R8: day and hour masked
        set_alarm(5, 9, 0, 10, 4'b1100);
        do_load(0, 0, 0, 9);
        ticks(1);
        chk("R8", int'(alarm_flag), 1);
        clear_flag();
        // R8: minute and second masked, hour carry triggers
        set_alarm(0, 1, 33, 33, 4'b0011);
        do_load(0, 0, 59, 59);
        ticks(1);
        chk("R8", int'(alarm_flag), 1);
        chk("R3", now(), packt(0, 1, 0, 0));
        clear_flag();
        // R8: seconds unmasked mismatch keeps flag low
        set_alarm(0, 0, 0, 40, 4'b1110);
        do_load(0, 0, 0, 10);
        ticks(1);
        chk("R8", int'(alarm_flag), 0);
        // R8: all masked, every tick sets
        set_alarm(0, 0, 0, 0, 4'b1111);
        ticks(1);
        chk("R8", int'(alarm_flag), 1);

        // R9: set wins over same-cycle clear
        flag_clr = 1;
        tick = 1;
        @(negedge clk);
        flag_clr = 0;
        tick = 0;
        chk("R9", int'(alarm_flag), 1);
        clear_flag();
        chk("R9", int'(alarm_flag), 0);

        // R1: reset mid-run
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R1", now(), 0);
        chk("R1", int'(alarm_flag), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule